// File: doc/BRIEF.md
# Endian Address Munging Unit

This unit sits between a bus master (a processor core or a DMA channel) and a 64-bit memory or I/O port. Before a request reaches the port, the unit may rewrite the low address bits and moves the request's data onto the byte lanes that the resulting address selects. Read data coming back is moved from those lanes down to the low-order bytes of the response. Three ordering modes are held in a small mode register: big-endian, true little-endian and munged little-endian. Only munged little-endian changes addresses. It does so by XORing the byte offset within the doubleword with a mask chosen by the access size.

DMA traffic does not follow the mode register. Each channel carries a two-bit byte-order code, and code `2'b01` selects munging for that channel. An interrupt-endian bit is copied into the active munged bit whenever the exception input fires, so the exception handler runs in the order that bit selects. For I/O accesses in munged mode the unit also mirrors the whole lane vector, so that a true little-endian device sees the bytes it would see from single-byte accesses.

Configuration writes take effect only while the system reports itself idle. Requests pass through a single register stage with a valid/ready handshake, in order. A request whose address is not aligned to its size is dropped and flagged.

Top module: `endian_lane_unit`

## Requirements
- R1: After reset, `mode_o` is 0 (big-endian), `ie_o`, `cfg_err_o`, `m_valid_o`, `align_err_o` and `rsp_valid_o` are 0.
- R2: With `idle_i` high, a mode write takes effect on `mode_o` at the next edge. The codes are 0 for big-endian, 1 for true little-endian and 2 for munged little-endian, and code 3 leaves the mode unchanged. An interrupt-endian write with `idle_i` high likewise updates `ie_o`.
- R3: A mode or interrupt-endian write made while `idle_i` is low changes neither `mode_o` nor `ie_o`. It sets `cfg_err_o`, which then stays high until reset.
- R4: When `exc_i` is high, `mode_o` becomes 2 at the next edge if `ie_o` was 1. If `ie_o` was 0, `mode_o` returns to the last non-munged mode (1 if true little-endian was last written, else 0). A mode write in the same cycle is dropped.
- R5: In modes 0 and 1, a core request leaves the port with `m_addr_o` equal to `req_addr_i`.
- R6: In mode 2, a core request's address bits [2:0] are XORed with 3'b111 for a byte (size 0), 3'b110 for a halfword (size 1), 3'b100 for a word (size 2) and 3'b000 for a doubleword (size 3). The upper bits are unchanged.
- R7: A DMA request (`req_dma_i` high) is munged with the R6 masks exactly when its channel's code in `chan_order_i[2*ch+1:2*ch]` is 2'b01, whatever the mode. Other codes pass the address through.
- R8: A request whose address is not a multiple of its size is accepted but not issued. `align_err_o` is high for the one cycle after acceptance, with `m_valid_o` low.
- R9: A write places the low n = 2^size bytes of `req_wdata_i` at the byte offsets o..o+n-1 of the modified address, most significant byte at offset o. Offset k maps to lane 7-k, where lane L is bits [8L+7:8L] and `m_be_o[L]`. Unselected lanes and enables are zero.
- R10: For each read issued, the next `m_rvalid_i` pulse yields `rsp_valid_o` one cycle later. `rsp_rdata_o` holds that read's lanes, gathered back by the R9 mapping into the low n bytes with zeros above. Responses are matched to reads in issue order.
- R11: When a request is munged and `req_io_i` is high, offset k maps to lane k instead of lane 7-k. This applies to enables, write data and read gathering alike.
- R12: An accepted aligned request appears on the port at the next edge. While `m_valid_o` is high and `m_ready_i` low, the port outputs hold and `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | No traffic in flight; configuration writes allowed |
| exc_i | input | 1 | Exception taken; load active munged bit from interrupt-endian bit |
| cfg_mode_we_i | input | 1 | Mode write strobe |
| cfg_mode_i | input | 2 | Mode code for the write |
| cfg_ie_we_i | input | 1 | Interrupt-endian write strobe |
| cfg_ie_i | input | 1 | Interrupt-endian value |
| chan_order_i | input | 2*NCHAN | Byte-order code per DMA channel |
| mode_o | output | 2 | Active mode |
| ie_o | output | 1 | Interrupt-endian bit |
| cfg_err_o | output | 1 | Sticky rejected-write flag |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when valid |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | Access size, log2 bytes |
| req_we_i | input | 1 | Write request |
| req_wdata_i | input | DW | Write data, low-order aligned |
| req_dma_i | input | 1 | Request from a DMA channel |
| req_chan_i | input | CHW | DMA channel number |
| req_io_i | input | 1 | Request targets an I/O device |
| m_valid_o | output | 1 | Port request valid |
| m_ready_i | input | 1 | Port accepts request |
| m_addr_o | output | AW | Modified address |
| m_we_o | output | 1 | Port write |
| m_be_o | output | DW/8 | Byte enables |
| m_wdata_o | output | DW | Steered write data |
| align_err_o | output | 1 | Misaligned request dropped |
| m_rvalid_i | input | 1 | Port read data valid |
| m_rdata_i | input | DW | Port read data |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | DW | Read data, low-order aligned |

## Verification
Several properties are checked on every cycle. The handshake holds its outputs under backpressure and blocks the input side. A misaligned acceptance gives an error pulse and no issue. Write data never occupies a lane whose enable is clear. The sticky error and its idle gating behave as specified, and an exception moves the mode according to the interrupt-endian bit. The exact address masks per size, the lane placement in each mode, DMA channel selection, I/O mirroring and in-order read gathering depend on concrete values. Only the directed scenarios, with expected values computed from the offset-to-lane rules, can show those.

// File: rtl/endian_pkg.sv
package endian_pkg;
  typedef enum logic [1:0] {
    MODE_BE  = 2'd0,
    MODE_TLE = 2'd1,
    MODE_MLE = 2'd2
  } endian_mode_e;

  localparam logic [1:0] ORDER_MUNGE = 2'b01;
endpackage

// File: rtl/endian_mode_ctl.sv
module endian_mode_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       idle_i,
  input  logic       exc_i,
  input  logic       mode_we_i,
  input  logic [1:0] mode_i,
  input  logic       ie_we_i,
  input  logic       ie_i,
  output logic [1:0] mode_o,
  output logic       ie_o,
  output logic       err_o
);
  import endian_pkg::*;

  logic tle_q, mle_q, ie_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tle_q <= 1'b0;
      mle_q <= 1'b0;
      ie_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if ((mode_we_i || ie_we_i) && !idle_i)
        err_q <= 1'b1;
      if (exc_i) begin
        mle_q <= ie_q;
      end else if (mode_we_i && idle_i) begin
        case (mode_i)
          MODE_BE:  begin tle_q <= 1'b0; mle_q <= 1'b0; end
          MODE_TLE: begin tle_q <= 1'b1; mle_q <= 1'b0; end
          MODE_MLE: begin tle_q <= 1'b0; mle_q <= 1'b1; end
          default:  ;
        endcase
      end
      if (ie_we_i && idle_i)
        ie_q <= ie_i;
    end
  end

  always_comb begin
    if (mle_q)      mode_o = MODE_MLE;
    else if (tle_q) mode_o = MODE_TLE;
    else            mode_o = MODE_BE;
  end

  assign ie_o  = ie_q;
  assign err_o = err_q;
endmodule

// File: rtl/endian_addr_map.sv
module endian_addr_map #(
  parameter int AW    = 32,
  parameter int OFF_W = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          munge_i,
  output logic [AW-1:0] addr_o,
  output logic          aligned_o
);
  logic [OFF_W-1:0] ones, xmask, szmask;

  always_comb begin
    ones      = '1;
    xmask     = munge_i ? (ones << size_i) : '0;
    szmask    = ~(ones << size_i);
    aligned_o = (addr_i[OFF_W-1:0] & szmask) == '0;
    addr_o    = {addr_i[AW-1:OFF_W], addr_i[OFF_W-1:0] ^ xmask};
  end
endmodule

// File: rtl/endian_rev.sv
module endian_rev #(
  parameter int N  = 8,
  parameter int EW = 8
) (
  input  logic [N*EW-1:0] d_i,
  input  logic            en_i,
  output logic [N*EW-1:0] d_o
);
  logic [N*EW-1:0] mirrored;

  for (genvar k = 0; k < N; k++) begin : g_el
    assign mirrored[k*EW +: EW] = d_i[(N-1-k)*EW +: EW];
  end

  assign d_o = en_i ? mirrored : d_i;
endmodule

// File: rtl/endian_rsp_fifo.sv
module endian_rsp_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_i)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign dout_o  = mem[rp];
  assign full_o  = cnt == (PW+1)'(DEPTH);
  assign empty_o = cnt == '0;
endmodule

// File: rtl/endian_lane_unit.sv
module endian_lane_unit #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int NCHAN = 4,
  parameter int DEPTH = 4,
  parameter int CHW   = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               idle_i,
  input  logic               exc_i,
  input  logic               cfg_mode_we_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic               cfg_ie_we_i,
  input  logic               cfg_ie_i,
  input  logic [2*NCHAN-1:0] chan_order_i,
  output logic [1:0]         mode_o,
  output logic               ie_o,
  output logic               cfg_err_o,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic               req_we_i,
  input  logic [DW-1:0]      req_wdata_i,
  input  logic               req_dma_i,
  input  logic [CHW-1:0]     req_chan_i,
  input  logic               req_io_i,
  output logic               m_valid_o,
  input  logic               m_ready_i,
  output logic [AW-1:0]      m_addr_o,
  output logic               m_we_o,
  output logic [DW/8-1:0]    m_be_o,
  output logic [DW-1:0]      m_wdata_o,
  output logic               align_err_o,
  input  logic               m_rvalid_i,
  input  logic [DW-1:0]      m_rdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o
);
  import endian_pkg::*;

  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int TAG_W = OFF_W + 3;

  // configuration state
  endian_mode_ctl u_mode (
    .clk(clk), .rst(rst), .idle_i(idle_i), .exc_i(exc_i),
    .mode_we_i(cfg_mode_we_i), .mode_i(cfg_mode_i),
    .ie_we_i(cfg_ie_we_i), .ie_i(cfg_ie_i),
    .mode_o(mode_o), .ie_o(ie_o), .err_o(cfg_err_o)
  );

  // munge decision per request
  logic [1:0] ch_code;
  logic       munge, mirror;
  assign ch_code = chan_order_i[req_chan_i*2 +: 2];
  assign munge   = req_dma_i ? (ch_code == ORDER_MUNGE) : (mode_o == MODE_MLE);
  assign mirror  = munge && req_io_i;

  logic [AW-1:0] addr_mod;
  logic          aligned;
  endian_addr_map #(.AW(AW), .OFF_W(OFF_W)) u_addr (
    .addr_i(req_addr_i), .size_i(req_size_i), .munge_i(munge),
    .addr_o(addr_mod), .aligned_o(aligned)
  );

  // write lane placement
  logic [OFF_W:0]    w_n, w_sh;
  logic [DW-1:0]     w_dmask, w_data_sh, w_data;
  logic [LANES-1:0]  w_be_base, w_be_sh, w_be;

  always_comb begin
    w_n       = (OFF_W+1)'(1) << req_size_i;
    w_sh      = (OFF_W+1)'(LANES) - w_n - {1'b0, addr_mod[OFF_W-1:0]};
    w_dmask   = ~({DW{1'b1}} << {w_n, 3'b000});
    w_data_sh = (req_wdata_i & w_dmask) << {w_sh, 3'b000};
    w_be_base = ~({LANES{1'b1}} << w_n);
    w_be_sh   = w_be_base << w_sh;
  end

  endian_rev #(.N(LANES), .EW(8)) u_wrev (.d_i(w_data_sh), .en_i(mirror), .d_o(w_data));
  endian_rev #(.N(LANES), .EW(1)) u_brev (.d_i(w_be_sh),   .en_i(mirror), .d_o(w_be));

  // request register stage
  logic fifo_full, fifo_empty, accept, push, pop;
  logic [TAG_W-1:0] tag_in, tag_out;

  assign req_ready_o = (!m_valid_o || m_ready_i) && !fifo_full;
  assign accept      = req_valid_i && req_ready_o;
  assign push        = accept && aligned && !req_we_i;
  assign pop         = m_rvalid_i && !fifo_empty;
  assign tag_in      = {mirror, req_size_i, addr_mod[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid_o   <= 1'b0;
      align_err_o <= 1'b0;
    end else begin
      align_err_o <= accept && !aligned;
      if (accept && aligned)  m_valid_o <= 1'b1;
      else if (m_ready_i)     m_valid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && aligned) begin
      m_addr_o  <= addr_mod;
      m_we_o    <= req_we_i;
      m_be_o    <= w_be;
      m_wdata_o <= req_we_i ? w_data : '0;
    end
  end

  // outstanding-read tags, issue order
  endian_rsp_fifo #(.W(TAG_W), .DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst(rst), .push_i(push), .din_i(tag_in), .pop_i(pop),
    .dout_o(tag_out), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  // read gather
  logic             r_mirror;
  logic [1:0]       r_size;
  logic [OFF_W-1:0] r_off;
  logic [OFF_W:0]   r_n, r_sh;
  logic [DW-1:0]    r_lanes, r_dmask, r_data;

  assign {r_mirror, r_size, r_off} = tag_out;

  endian_rev #(.N(LANES), .EW(8)) u_rrev (.d_i(m_rdata_i), .en_i(r_mirror), .d_o(r_lanes));

  always_comb begin
    r_n     = (OFF_W+1)'(1) << r_size;
    r_sh    = (OFF_W+1)'(LANES) - r_n - {1'b0, r_off};
    r_dmask = ~({DW{1'b1}} << {r_n, 3'b000});
    r_data  = (r_lanes >> {r_sh, 3'b000}) & r_dmask;
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_valid_o <= 1'b0;
    else     rsp_valid_o <= pop;
  end

  always_ff @(posedge clk) begin
    if (pop) rsp_rdata_o <= r_data;
  end
endmodule

// File: rtl/endian_lane_unit_chk.sv
module endian_lane_unit_chk #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            idle_i,
  input logic            exc_i,
  input logic            cfg_mode_we_i,
  input logic [1:0]      mode_o,
  input logic            ie_o,
  input logic            cfg_err_o,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [AW-1:0]   req_addr_i,
  input logic [1:0]      req_size_i,
  input logic            m_valid_o,
  input logic            m_ready_i,
  input logic [AW-1:0]   m_addr_o,
  input logic            m_we_o,
  input logic [DW/8-1:0] m_be_o,
  input logic [DW-1:0]   m_wdata_o,
  input logic            align_err_o,
  input logic            m_rvalid_i,
  input logic            rsp_valid_o
);
  logic [DW-1:0] lane_mask;
  for (genvar k = 0; k < DW/8; k++) begin : g_lm
    assign lane_mask[k*8 +: 8] = {8{m_be_o[k]}};
  end

  logic misal;
  always_comb begin
    case (req_size_i)
      2'd0:    misal = 1'b0;
      2'd1:    misal = req_addr_i[0];
      2'd2:    misal = |req_addr_i[1:0];
      default: misal = |req_addr_i[2:0];
    endcase
  end

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_addr_o) && $stable(m_be_o) && $stable(m_wdata_o));

  // R12
  no_accept_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid_o && !m_ready_i |-> !req_ready_o);

  // R12
  issue_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_ready_o && !misal |=> m_valid_o && !align_err_o);

  // R8
  misaligned_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_ready_o && misal |=> align_err_o && !m_valid_o);

  // R9
  no_data_off_lane_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid_o && m_we_o |-> (m_wdata_o & ~lane_mask) == '0);

  // R9
  some_lane_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> m_be_o != '0);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o);

  // R3
  busy_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mode_we_i && !idle_i && !exc_i |=> cfg_err_o && $stable(mode_o));

  // R4
  exc_to_munged_chk: assert property (@(posedge clk) disable iff (rst)
    exc_i && ie_o |=> mode_o == 2'd2);

  // R4
  exc_to_plain_chk: assert property (@(posedge clk) disable iff (rst)
    exc_i && !ie_o |=> mode_o != 2'd2);

  // R10
  rsp_follows_port_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |-> $past(m_rvalid_i));
endmodule

bind endian_lane_unit endian_lane_unit_chk #(.AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_endian_lane_unit.sv
module test_endian_lane_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic idle_i = 1'b1, exc_i = 1'b0;
  logic cfg_mode_we_i = 1'b0, cfg_ie_we_i = 1'b0, cfg_ie_i = 1'b0;
  logic [1:0] cfg_mode_i = 2'd0;
  logic [7:0] chan_order_i = 8'h00;
  logic [1:0] mode_o;
  logic ie_o, cfg_err_o;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [1:0] req_size_i = '0;
  logic req_we_i = 1'b0, req_dma_i = 1'b0, req_io_i = 1'b0;
  logic [63:0] req_wdata_i = '0;
  logic [1:0] req_chan_i = '0;
  logic m_valid_o, m_ready_i = 1'b1, m_we_o, align_err_o;
  logic [31:0] m_addr_o;
  logic [7:0] m_be_o;
  logic [63:0] m_wdata_o, rsp_rdata_o;
  logic m_rvalid_i = 1'b0, rsp_valid_o;
  logic [63:0] m_rdata_i = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_lane_unit i_endian_lane_unit (.*);

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int lane_of(input int off, input bit mir);
    return mir ? off : 7 - off;
  endfunction

  function automatic logic [7:0] f_be(input int off, input int sz, input bit mir);
    logic [7:0] b = '0;
    for (int j = 0; j < (1 << sz); j++) b[lane_of(off + j, mir)] = 1'b1;
    return b;
  endfunction

  function automatic logic [63:0] f_wd(input int off, input int sz, input bit mir, input logic [63:0] wd);
    logic [63:0] d = '0;
    int n = 1 << sz;
    for (int j = 0; j < n; j++) d[lane_of(off + j, mir)*8 +: 8] = wd[(n-1-j)*8 +: 8];
    return d;
  endfunction

  function automatic logic [63:0] f_rd(input int off, input int sz, input bit mir, input logic [63:0] rd);
    logic [63:0] d = '0;
    int n = 1 << sz;
    for (int j = 0; j < n; j++) d[(n-1-j)*8 +: 8] = rd[lane_of(off + j, mir)*8 +: 8];
    return d;
  endfunction

  function automatic logic [2:0] f_xm(input int sz);
    case (sz)
      0: return 3'b111;
      1: return 3'b110;
      2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic set_mode(input logic [1:0] code, input logic idle);
    @(negedge clk);
    cfg_mode_we_i = 1'b1; cfg_mode_i = code; idle_i = idle;
    @(negedge clk);
    cfg_mode_we_i = 1'b0; idle_i = 1'b1;
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk);
    cfg_ie_we_i = 1'b1; cfg_ie_i = v;
    @(negedge clk);
    cfg_ie_we_i = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input int sz, input logic we, input logic [63:0] wd,
                      input logic dma, input logic [1:0] ch, input logic io);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a; req_size_i = 2'(sz); req_we_i = we;
    req_wdata_i = wd; req_dma_i = dma; req_chan_i = ch; req_io_i = io;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wr_chk(input string r, input logic [31:0] a, input int sz, input logic [63:0] wd,
                        input logic dma, input logic [1:0] ch, input logic io,
                        input logic [2:0] xm, input bit mir);
    logic [31:0] ea;
    ea = {a[31:3], a[2:0] ^ xm};
    send(a, sz, 1'b1, wd, dma, ch, io);
    chk({r, " valid"}, 64'(m_valid_o), 64'd1);
    chk({r, " addr"},  64'(m_addr_o), 64'(ea));
    chk({r, " be"},    64'(m_be_o), 64'(f_be(int'(ea[2:0]), sz, mir)));
    chk({r, " data"},  m_wdata_o, f_wd(int'(ea[2:0]), sz, mir, wd));
  endtask

  task automatic t_reset;
    chk("R1 mode", 64'(mode_o), 64'd0);
    chk("R1 ie", 64'(ie_o), 64'd0);
    chk("R1 err", 64'(cfg_err_o), 64'd0);
    chk("R1 valid", 64'(m_valid_o), 64'd0);
    chk("R1 aerr", 64'(align_err_o), 64'd0);
    chk("R1 rsp", 64'(rsp_valid_o), 64'd0);
  endtask

  task automatic t_big_endian;
    wr_chk("R5 R9 be word", 32'h100, 2, 64'h11223344, 0, 0, 0, 3'b000, 0);
    wr_chk("R5 R9 be byte7", 32'h107, 0, 64'hAB, 0, 0, 0, 3'b000, 0);
    wr_chk("R5 R9 be dword", 32'h108, 3, 64'h0102030405060708, 0, 0, 1, 3'b000, 0);
  endtask

  task automatic t_true_le;
    set_mode(2'd1, 1'b1);
    chk("R2 tle", 64'(mode_o), 64'd1);
    wr_chk("R5 tle half", 32'h202, 1, 64'hBEEF, 0, 0, 0, 3'b000, 0);
    set_mode(2'd3, 1'b1);
    chk("R2 code3 keeps", 64'(mode_o), 64'd1);
  endtask

  task automatic t_munged;
    set_mode(2'd2, 1'b1);
    chk("R2 mle", 64'(mode_o), 64'd2);
    for (int sz = 0; sz < 4; sz++) begin
      wr_chk("R6 R9 mle", 32'h300 + 32'(1 << sz) * 32'(sz == 0 ? 3 : 1) * 32'(sz < 3),
             sz, 64'hF1E2D3C4B5A69788, 0, 0, 0, f_xm(sz), 0);
    end
    wr_chk("R6 mle byte0", 32'h1003, 0, 64'hAB, 0, 0, 0, 3'b111, 0);
  endtask

  task automatic t_dma;
    chan_order_i = 8'b00_01_10_01;
    set_mode(2'd0, 1'b1);
    wr_chk("R7 dma ch2 munged", 32'h401, 0, 64'h5A, 1, 2'd2, 0, 3'b111, 0);
    wr_chk("R7 dma ch0 half", 32'h402, 1, 64'h1234, 1, 2'd0, 0, 3'b110, 0);
    wr_chk("R7 dma ch1 plain", 32'h401, 0, 64'h5A, 1, 2'd1, 0, 3'b000, 0);
    set_mode(2'd2, 1'b1);
    wr_chk("R7 dma ch3 plain in mle", 32'h404, 2, 64'hCAFEF00D, 1, 2'd3, 0, 3'b000, 0);
  endtask

  task automatic t_io_mirror;
    set_mode(2'd2, 1'b1);
    wr_chk("R11 io byte", 32'h500, 0, 64'hAB, 0, 0, 1, 3'b111, 1);
    wr_chk("R11 io word", 32'h504, 2, 64'h01020304, 0, 0, 1, 3'b100, 1);
  endtask

  task automatic t_align;
    send(32'h101, 1, 1'b1, 64'h1, 0, 0, 0);
    chk("R8 half odd err", 64'(align_err_o), 64'd1);
    chk("R8 half odd noissue", 64'(m_valid_o), 64'd0);
    send(32'h104, 3, 1'b0, 64'h0, 0, 0, 0);
    chk("R8 dword err", 64'(align_err_o), 64'd1);
    chk("R8 dword noissue", 64'(m_valid_o), 64'd0);
    @(negedge clk);
    chk("R8 pulse one cycle", 64'(align_err_o), 64'd0);
  endtask

  task automatic t_reads;
    logic [63:0] d1, d2;
    d1 = 64'h8877665544332211;
    d2 = 64'h0F1E2D3C4B5A6978;
    set_mode(2'd2, 1'b1);
    send(32'h600, 2, 1'b0, 64'h0, 0, 0, 0);
    chk("R6 rd addr", 64'(m_addr_o), 64'h604);
    send(32'h601, 0, 1'b0, 64'h0, 0, 0, 1);
    chk("R11 rd io addr", 64'(m_addr_o), 64'h606);
    @(negedge clk);
    m_rvalid_i = 1'b1; m_rdata_i = d1;
    @(negedge clk);
    m_rvalid_i = 1'b0;
    chk("R10 rsp1 valid", 64'(rsp_valid_o), 64'd1);
    chk("R10 rsp1 data", rsp_rdata_o, f_rd(4, 2, 0, d1));
    @(negedge clk);
    chk("R10 rsp idle", 64'(rsp_valid_o), 64'd0);
    m_rvalid_i = 1'b1; m_rdata_i = d2;
    @(negedge clk);
    m_rvalid_i = 1'b0;
    chk("R10 R11 rsp2 data", rsp_rdata_o, f_rd(6, 0, 1, d2));
    set_mode(2'd0, 1'b1);
    send(32'h708, 3, 1'b0, 64'h0, 0, 0, 0);
    @(negedge clk);
    m_rvalid_i = 1'b1; m_rdata_i = d1;
    @(negedge clk);
    m_rvalid_i = 1'b0;
    chk("R10 be dword rd", rsp_rdata_o, d1);
  endtask

  task automatic t_backpressure;
    m_ready_i = 1'b0;
    send(32'h800, 1, 1'b1, 64'h7788, 0, 0, 0);
    chk("R12 issued", 64'(m_valid_o), 64'd1);
    chk("R12 ready low", 64'(req_ready_o), 64'd0);
    @(negedge clk);
    chk("R12 held valid", 64'(m_valid_o), 64'd1);
    chk("R12 held addr", 64'(m_addr_o), 64'h800);
    m_ready_i = 1'b1;
    @(negedge clk);
    chk("R12 drained", 64'(m_valid_o), 64'd0);
  endtask

  task automatic t_exception;
    set_mode(2'd1, 1'b1);
    set_ie(1'b1);
    chk("R2 ie write", 64'(ie_o), 64'd1);
    @(negedge clk); exc_i = 1'b1;
    @(negedge clk); exc_i = 1'b0;
    chk("R4 exc ie1", 64'(mode_o), 64'd2);
    set_ie(1'b0);
    @(negedge clk); exc_i = 1'b1; cfg_mode_we_i = 1'b1; cfg_mode_i = 2'd2;
    @(negedge clk); exc_i = 1'b0; cfg_mode_we_i = 1'b0;
    chk("R4 exc ie0 back to tle, write dropped", 64'(mode_o), 64'd1);
  endtask

  task automatic t_busy_cfg;
    set_mode(2'd0, 1'b1);
    chk("R3 err clear before", 64'(cfg_err_o), 64'd0);
    set_mode(2'd2, 1'b0);
    chk("R3 busy write ignored", 64'(mode_o), 64'd0);
    chk("R3 err set", 64'(cfg_err_o), 64'd1);
    @(negedge clk);
    cfg_ie_we_i = 1'b1; cfg_ie_i = 1'b1; idle_i = 1'b0;
    @(negedge clk);
    cfg_ie_we_i = 1'b0; idle_i = 1'b1;
    chk("R3 busy ie ignored", 64'(ie_o), 64'd0);
    set_mode(2'd1, 1'b1);
    chk("R3 idle write works", 64'(mode_o), 64'd1);
    chk("R3 err sticky", 64'(cfg_err_o), 64'd1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_big_endian();
    t_true_le();
    t_munged();
    t_dma();
    t_io_mirror();
    t_align();
    t_reads();
    t_backpressure();
    t_exception();
    t_busy_cfg();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end
endmodule